// File: doc/BRIEF.md
# ADC Window Watchdog Comparator

This block watches the stream of finished conversion results from an analog-to-digital converter. It raises an event when a result falls outside a programmable window. Each result comes with a valid strobe, a channel number and a tag that marks it as a regular-group or an inserted-group result. The result is tested against a low bound and a high bound only when its group's watchdog enable is set and it passes the channel filter.

The comparison uses the raw, unaligned converter code. A threshold therefore keeps its meaning whichever data alignment the converter later applies. The channel filter works in one of two modes. In guard-one mode, only the channel whose index equals the channel selector is checked. In guard-all mode, every channel of an enabled group is checked.

An out-of-window hit sets a sticky event flag one clock after the strobe. The flag stays set until software pulses a clear input. The interrupt output is the flag gated by an interrupt enable.

Top module: `adc_wd`

## Requirements
- R1: After reset, `flag_o` and `irq_o` are 0.
- R2: A regular-group result (`res_inserted_i`=0) is checked only when `reg_en_i` is 1. Otherwise it leaves the flag unchanged.
- R3: An inserted-group result (`res_inserted_i`=1) is checked only when `ins_en_i` is 1. Otherwise it leaves the flag unchanged.
- R4: A checked result whose raw 12-bit code is strictly below `thr_low_i` sets the flag. A result equal to `thr_low_i` does not set it.
- R5: A checked result strictly above `thr_high_i` sets the flag. A result equal to `thr_high_i` does not set it.
- R6: `irq_o` is 1 exactly when `flag_o` is 1 and `irq_en_i` is 1.
- R7: When `single_chan_i` is 1, only results with `res_chan_i` equal to `sel_chan_i` are checked.
- R8: When `single_chan_i` is 0, results on every channel of an enabled group are checked.
- R9: The flag is sticky. A pulse on `flag_clr_i` clears it. A hit in the same cycle as a clear leaves it set.
- R10: Inputs are evaluated only in a cycle where `res_valid_i` is 1. The flag reflects the hit at the next clock edge.
- R11: When `thr_low_i` is greater than `thr_high_i`, every checked valid result sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_valid_i | input | 1 | Result-valid strobe |
| res_data_i | input | 12 | Raw conversion code |
| res_chan_i | input | 5 | Channel of the result |
| res_inserted_i | input | 1 | Group tag: 0 regular, 1 inserted |
| reg_en_i | input | 1 | Watchdog enable for regular results |
| ins_en_i | input | 1 | Watchdog enable for inserted results |
| single_chan_i | input | 1 | 1: guard one channel, 0: guard all channels |
| sel_chan_i | input | 5 | Guarded channel in guard-one mode |
| thr_low_i | input | 12 | Low bound (inclusive inside) |
| thr_high_i | input | 12 | High bound (inclusive inside) |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Clear pulse for the event flag |
| flag_o | output | 1 | Sticky watchdog event flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A software clear and a fresh out-of-window hit can land in the same cycle. The bench provokes this by raising `flag_clr_i` in a cycle where a valid, checked result sits below the low bound, both while the flag is already set and while it is clear. The outcome is judged one edge later: the flag must read 1, and when the clear is paired with an in-window result instead, it must read 0. Random cycles also assert clear and valid together often, and every cycle is compared against a bench model in which set takes priority.

// File: rtl/adc_wd_pkg.sv
package adc_wd_pkg;
  localparam int unsigned DATA_W = 12;
  localparam int unsigned CHAN_W = 5;

  typedef enum logic {
    GRP_REGULAR  = 1'b0,
    GRP_INSERTED = 1'b1
  } grp_e;

  typedef struct packed {
    logic              valid;
    grp_e              grp;
    logic [CHAN_W-1:0] chan;
    logic [DATA_W-1:0] data;
  } result_t;
endpackage

// File: rtl/adc_wd_window.sv
module adc_wd_window #(
  parameter int unsigned DATA_W = 12
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] low_i,
  input  logic [DATA_W-1:0] high_i,
  output logic              outside_o
);
  logic below, above;
  assign below     = data_i < low_i;
  assign above     = data_i > high_i;
  assign outside_o = below | above;
endmodule

// File: rtl/adc_wd_select.sv
module adc_wd_select
  import adc_wd_pkg::*;
#(
  parameter int unsigned NUM_GRP = 2
) (
  input  result_t           res_i,
  input  logic [NUM_GRP-1:0] grp_en_i,
  input  logic              single_i,
  input  logic [CHAN_W-1:0] sel_chan_i,
  output logic              watched_o
);
  logic [NUM_GRP-1:0] grp_hit;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign grp_hit[g] = grp_en_i[g] && (int'(res_i.grp) == g);
  end

  logic chan_ok;
  assign chan_ok   = !single_i || (res_i.chan == sel_chan_i);
  assign watched_o = res_i.valid && (|grp_hit) && chan_ok;
endmodule

// File: rtl/adc_wd_flag.sv
module adc_wd_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;  // set wins over clear
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/adc_wd.sv
module adc_wd
  import adc_wd_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned CW = CHAN_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          res_valid_i,
  input  logic [DW-1:0] res_data_i,
  input  logic [CW-1:0] res_chan_i,
  input  logic          res_inserted_i,
  input  logic          reg_en_i,
  input  logic          ins_en_i,
  input  logic          single_chan_i,
  input  logic [CW-1:0] sel_chan_i,
  input  logic [DW-1:0] thr_low_i,
  input  logic [DW-1:0] thr_high_i,
  input  logic          irq_en_i,
  input  logic          flag_clr_i,
  output logic          flag_o,
  output logic          irq_o
);
  localparam int unsigned NUM_GRP = 2;

  result_t            res;
  logic [NUM_GRP-1:0] grp_en;
  logic               watched, outside, hit;

  assign res.valid = res_valid_i;
  assign res.grp   = res_inserted_i ? GRP_INSERTED : GRP_REGULAR;
  assign res.chan  = res_chan_i;
  assign res.data  = res_data_i;

  assign grp_en[GRP_REGULAR]  = reg_en_i;
  assign grp_en[GRP_INSERTED] = ins_en_i;

  adc_wd_select #(.NUM_GRP(NUM_GRP)) u_select (
    .res_i      (res),
    .grp_en_i   (grp_en),
    .single_i   (single_chan_i),
    .sel_chan_i (sel_chan_i),
    .watched_o  (watched)
  );

  adc_wd_window #(.DATA_W(DW)) u_window (
    .data_i    (res_data_i),
    .low_i     (thr_low_i),
    .high_i    (thr_high_i),
    .outside_o (outside)
  );

  assign hit = watched && outside;

  adc_wd_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (hit),
    .clr_i  (flag_clr_i),
    .flag_o (flag_o)
  );

  assign irq_o = flag_o && irq_en_i;
endmodule

module adc_wd_chk #(
  parameter int unsigned DW = 12,
  parameter int unsigned CW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          res_valid_i,
  input logic [DW-1:0] res_data_i,
  input logic [CW-1:0] res_chan_i,
  input logic          res_inserted_i,
  input logic          reg_en_i,
  input logic          ins_en_i,
  input logic          single_chan_i,
  input logic [CW-1:0] sel_chan_i,
  input logic [DW-1:0] thr_low_i,
  input logic [DW-1:0] thr_high_i,
  input logic          irq_en_i,
  input logic          flag_clr_i,
  input logic          flag_o,
  input logic          irq_o
);
  logic grp_on;
  assign grp_on = res_inserted_i ? ins_en_i : reg_en_i;

  assert_rise_on_valid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(res_valid_i));

  assert_fall_on_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_o) |-> $past(flag_clr_i));

  assert_irq_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag_o && irq_en_i));

  assert_irq_present_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && irq_en_i) |-> irq_o);

  assert_inside_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!flag_o && res_data_i >= thr_low_i && res_data_i <= thr_high_i) |-> !flag_o);

  assert_inverted_window_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(res_valid_i && grp_on && !single_chan_i && thr_low_i > thr_high_i) |-> flag_o);

  assert_off_group_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!flag_o && !grp_on) |-> !flag_o);

  assert_off_channel_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!flag_o && single_chan_i && res_chan_i != sel_chan_i) |-> !flag_o);
endmodule

bind adc_wd adc_wd_chk #(.DW(DW), .CW(CW)) u_chk (.*);

// File: tb/adc_wd_bench.sv
module adc_wd_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic valid = 0, ins = 0, reg_en = 0, ins_en = 0, single = 0, irq_en = 0, clr = 0;
  logic [11:0] data = 0, lo = 0, hi = 0;
  logic [4:0] chan = 0, sel = 0;
  logic flag, irq;
  int checks = 0, errors = 0;
  logic exp_flag = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_wd u_adc_wd (
    .clk_i(clk), .rst_ni(rst_n), .res_valid_i(valid), .res_data_i(data),
    .res_chan_i(chan), .res_inserted_i(ins), .reg_en_i(reg_en), .ins_en_i(ins_en),
    .single_chan_i(single), .sel_chan_i(sel), .thr_low_i(lo), .thr_high_i(hi),
    .irq_en_i(irq_en), .flag_clr_i(clr), .flag_o(flag), .irq_o(irq));

  function automatic logic model_hit();
    logic g, c;
    g = ins ? ins_en : reg_en;
    c = !single || (chan == sel);
    return valid && g && c && (data < lo || data > hi);
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // inputs are already set at a negedge; advance one cycle and compare
  task automatic step(string req);
    logic h;
    h = model_hit();
    exp_flag = h ? 1'b1 : (clr ? 1'b0 : exp_flag);
    @(posedge clk);
    @(negedge clk);
    check({req, " flag"}, flag, exp_flag);
    check("R6 irq", irq, exp_flag && irq_en);
    valid = 0; clr = 0;
  endtask

  task automatic res(logic i, logic [4:0] c, logic [11:0] d);
    valid = 1; ins = i; chan = c; data = d;
  endtask

  task automatic do_clear();
    clr = 1; step("R9 clear");
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (2) @(negedge clk);
    check("R1 flag", flag, 1'b0);
    check("R1 irq", irq, 1'b0);
    rst_n = 1;
    @(negedge clk);
    lo = 12'd100; hi = 12'd3000; reg_en = 1; ins_en = 0; irq_en = 1;

    // R4 boundaries
    res(0, 3, 12'd100); step("R4 equal low");
    res(0, 3, 12'd99);  step("R4 below low");
    do_clear();
    // R5 boundaries
    res(0, 3, 12'd3000); step("R5 equal high");
    res(0, 3, 12'd3001); step("R5 above high");
    irq_en = 0; step("R6 irq off");
    irq_en = 1; step("R6 irq on");
    do_clear();
    // R10: outside data without strobe
    data = 12'd5; chan = 3; ins = 0; valid = 0; step("R10 no strobe");
    // R2/R3 group gating
    res(1, 2, 12'd5); step("R3 inserted disabled");
    reg_en = 0; res(0, 2, 12'd5); step("R2 regular disabled");
    ins_en = 1; res(1, 2, 12'd5); step("R3 inserted enabled");
    do_clear();
    reg_en = 1; res(0, 2, 12'd4000); step("R2 regular enabled");
    do_clear();
    // R7/R8 channel filter
    single = 1; sel = 5'd17;
    res(0, 16, 12'd5); step("R7 other channel");
    res(0, 17, 12'd5); step("R7 chosen channel");
    do_clear();
    single = 0; res(1, 31, 12'd4095); step("R8 all channels");
    // R9 set and clear together, flag set and flag clear
    res(0, 0, 12'd0); clr = 1; step("R9 set wins (flag high)");
    do_clear();
    res(0, 0, 12'd0); clr = 1; step("R9 set wins (flag low)");
    res(0, 0, 12'd500); clr = 1; step("R9 clear with inside result");
    step("R9 sticky idle");
    // R11 inverted window
    lo = 12'd2000; hi = 12'd1000;
    res(0, 7, 12'd1500); step("R11 inverted mid");
    do_clear();
    res(1, 7, 12'd2000); step("R11 inverted edge");
    do_clear();

    // random mix
    for (int n = 0; n < 3000; n++) begin
      valid  = $urandom_range(0, 3) != 0;
      ins    = $urandom_range(0, 1);
      chan   = 5'($urandom_range(0, 31));
      data   = 12'($urandom_range(0, 4095));
      reg_en = $urandom_range(0, 3) != 0;
      ins_en = $urandom_range(0, 3) != 0;
      single = $urandom_range(0, 2) == 0;
      sel    = $urandom_range(0, 1) ? chan : 5'($urandom_range(0, 31));
      lo     = 12'($urandom_range(0, 1500));
      hi     = 12'($urandom_range(1000, 4095));
      irq_en = $urandom_range(0, 1);
      clr    = $urandom_range(0, 3) == 0;
      step("R10 random");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog timeout actual=hang expected=finish");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule